// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block turns a byte-wide command stream, as delivered by a host FIFO link, into reads and writes on a small internal 8-bit register space. Each command byte holds a 4-bit opcode in bits 7:4 and a 4-bit payload in bits 3:0. An 8-bit register address is built from two nibble commands, and write data is built the same way. The high-data command commits the assembled byte. A read command puts one byte on the return stream and can post-increment the address, so that a run of reads walks through neighbouring registers.

The register space holds a fixed identification byte, a scratch register for link sanity checks, a mode register that turns each written one bit into a single-cycle request strobe, and two 24-bit position values that are brought in from the capture logic and read out one byte at a time. At most one command is accepted per clock. A response byte appears on the cycle after its read command.

Top module: `nib_reg_decoder`

## Requirements
- R1: Opcode 0x0 loads payload into address bits 3:0 and opcode 0x1 loads payload into address bits 7:4. Each leaves the other half unchanged. The address holds when no command is accepted and is 0x00 after reset.
- R2: Opcode 0x2 holds payload as the low data nibble and writes nothing. Opcode 0x3 writes the byte {payload, held low nibble} to the current address.
- R3: Several low/high data pairs after one address setup all write the same address, because writes never advance it. The last pair's byte is the one that stays.
- R4: Opcode 0x4 (read) gives exactly one response: rsp_valid_o is high for one cycle, on the cycle after the command, with the byte of the register addressed when the command was accepted. rsp_valid_o is low at all other times.
- R5: A read with payload bit 0 set advances the address by one after the read, wrapping from 0xFF to 0x00. With bit 0 clear the address is kept.
- R6: Address 0x00 reads 0xA6, and writes to it have no effect.
- R7: Address 0x01 is a scratch register that reads back the last byte written to it. It reads 0x00 after reset.
- R8: Addresses 0x10 to 0x15 read the trigger position and then the stop position, least significant byte first (0x10 = trigger bits 7:0, 0x13 = stop bits 7:0). Writes to these addresses have no effect.
- R9: A write to address 0x02 drives mode_strobe_o with the written byte for exactly one cycle, the cycle after the write command. At all other times mode_strobe_o is 0x00, and address 0x02 reads 0x00.
- R10: Opcodes 0x5 to 0xF change no state and produce no response. Unmapped addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_byte_i | input | 8 | Command: opcode in 7:4, payload in 3:0 |
| trig_pos_i | input | 24 | Trigger position value from capture logic |
| stop_pos_i | input | 24 | Stop position value from capture logic |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_byte_o | output | 8 | Response byte for a read |
| mode_strobe_o | output | 8 | One-cycle request pulses, one per mode bit written as one |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data and 24-bit positions. With these sizes the whole address space can be swept. Every address is set up through both nibble commands and read back against a map computed in the bench. A single incrementing read run covers all 256 addresses and confirms the wrap to 0x00. All 256 scratch values are written and read back. The bench also checks mode strobes for several patterns, the stale-pair and ignored-opcode cases, and writes to read-only addresses.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_HI = 4'h3,
    OP_READ    = 4'h4
  } opcode_e;

  localparam logic [7:0] ID_ADDR      = 8'h00;
  localparam logic [7:0] SCRATCH_ADDR = 8'h01;
  localparam logic [7:0] MODE_ADDR    = 8'h02;
  localparam logic [7:0] POS_BASE     = 8'h10;
  localparam logic [7:0] ID_VALUE     = 8'hA6;
endpackage

// File: rtl/nrd_cmd_parse.sv
module nrd_cmd_parse
  import nrd_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic               valid_i,
  input  logic [2*NIB_W-1:0] byte_i,
  output logic               addr_lo_o,
  output logic               addr_hi_o,
  output logic               dat_lo_o,
  output logic               dat_hi_o,
  output logic               rd_o,
  output logic               rd_inc_o,
  output logic [NIB_W-1:0]   nib_o
);
  logic [OP_W-1:0] op;

  assign op    = byte_i[2*NIB_W-1 -: OP_W];
  assign nib_o = byte_i[NIB_W-1:0];

  always_comb begin
    addr_lo_o = 1'b0;
    addr_hi_o = 1'b0;
    dat_lo_o  = 1'b0;
    dat_hi_o  = 1'b0;
    rd_o      = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_ADDR_LO: addr_lo_o = 1'b1;
        OP_ADDR_HI: addr_hi_o = 1'b1;
        OP_DATA_LO: dat_lo_o  = 1'b1;
        OP_DATA_HI: dat_hi_o  = 1'b1;
        OP_READ:    rd_o      = 1'b1;
        default: ;
      endcase
    end
    rd_inc_o = rd_o & byte_i[0];
  end
endmodule

// File: rtl/nrd_addr_data.sv
module nrd_addr_data #(
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned ADDR_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_lo_i,
  input  logic              addr_hi_i,
  input  logic              dat_lo_i,
  input  logic              dat_hi_i,
  input  logic              rd_inc_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      if (addr_lo_i) addr_q[NIB_W-1:0] <= nib_i;
      if (addr_hi_i) addr_q[ADDR_W-1:NIB_W] <= nib_i;
      if (rd_inc_i)  addr_q <= addr_q + ADDR_W'(1);
      if (dat_lo_i)  lo_q <= nib_i;
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = dat_hi_i;
  assign wr_data_o = {nib_i, lo_q};
endmodule

// File: rtl/nrd_regfile.sv
module nrd_regfile
  import nrd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 24,
  localparam int unsigned POS_BYTES = POS_W / DATA_W,
  localparam int unsigned N_POS     = 2 * POS_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [POS_W-1:0]  trig_pos_i,
  input  logic [POS_W-1:0]  stop_pos_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_byte_o,
  output logic [DATA_W-1:0] strobe_o
);
  logic [DATA_W-1:0]   scratch_q;
  logic [DATA_W-1:0]   strobe_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_q;
  logic [DATA_W-1:0]   rd_data;
  logic [2*POS_W-1:0]  pos_cat;
  logic [DATA_W-1:0]   pos_byte [N_POS];
  logic [N_POS-1:0]    pos_hit;

  assign pos_cat = {stop_pos_i, trig_pos_i};

  for (genvar k = 0; k < N_POS; k++) begin : g_pos
    assign pos_byte[k] = pos_cat[k*DATA_W +: DATA_W];
    assign pos_hit[k]  = (addr_i == DATA_W'(POS_BASE + k));
  end

  always_comb begin
    rd_data = '0;
    if (addr_i == ID_ADDR)      rd_data = ID_VALUE;
    if (addr_i == SCRATCH_ADDR) rd_data = scratch_q;
    for (int k = 0; k < N_POS; k++) begin
      if (pos_hit[k]) rd_data = pos_byte[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q   <= '0;
      strobe_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else begin
      if (wr_en_i && addr_i == SCRATCH_ADDR) scratch_q <= wr_data_i;
      strobe_q    <= (wr_en_i && addr_i == MODE_ADDR) ? wr_data_i : '0;
      rsp_valid_q <= rd_i;
      if (rd_i) rsp_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_byte_o  = rsp_q;
  assign strobe_o    = strobe_q;
endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned POS_W = 24,
  localparam int unsigned DATA_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  input  logic [POS_W-1:0]  trig_pos_i,
  input  logic [POS_W-1:0]  stop_pos_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_byte_o,
  output logic [DATA_W-1:0] mode_strobe_o
);
  logic              addr_lo, addr_hi, dat_lo, dat_hi, rd, rd_inc;
  logic [NIB_W-1:0]  nib;
  logic [DATA_W-1:0] addr_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  nrd_cmd_parse #(.NIB_W(NIB_W)) parse_i (
    .valid_i  (cmd_valid_i),
    .byte_i   (cmd_byte_i),
    .addr_lo_o(addr_lo),
    .addr_hi_o(addr_hi),
    .dat_lo_o (dat_lo),
    .dat_hi_o (dat_hi),
    .rd_o     (rd),
    .rd_inc_o (rd_inc),
    .nib_o    (nib)
  );

  nrd_addr_data #(.NIB_W(NIB_W)) hold_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_lo_i(addr_lo),
    .addr_hi_i(addr_hi),
    .dat_lo_i (dat_lo),
    .dat_hi_i (dat_hi),
    .rd_inc_i (rd_inc),
    .nib_i    (nib),
    .addr_o   (addr_q),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data)
  );

  nrd_regfile #(.DATA_W(DATA_W), .POS_W(POS_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_q),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_i       (rd),
    .trig_pos_i (trig_pos_i),
    .stop_pos_i (stop_pos_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_byte_o (rsp_byte_o),
    .strobe_o   (mode_strobe_o)
  );
endmodule

// File: rtl/nrd_checker.sv
module nrd_checker
  import nrd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_byte_i,
  input logic       rsp_valid_o,
  input logic [7:0] rsp_byte_o,
  input logic [7:0] mode_strobe_o,
  input logic [7:0] addr_q
);
  logic is_rd, is_wr;
  assign is_rd = cmd_valid_i && cmd_byte_i[7:4] == OP_READ;
  assign is_wr = cmd_valid_i && cmd_byte_i[7:4] == OP_DATA_HI;

  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(addr_q)); // R1

  AST_RSP_ONE_PER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(is_rd)); // R4

  AST_RD_POST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && cmd_byte_i[0]) |=> addr_q == $past(addr_q) + 8'd1); // R5

  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && addr_q == ID_ADDR) |=> rsp_byte_o == ID_VALUE); // R6

  AST_STROBE_ONLY_ON_MODE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_strobe_o != 8'h00) |-> $past(is_wr && addr_q == MODE_ADDR)); // R9

  AST_WR_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> $stable(addr_q)); // R3
endmodule

bind nib_reg_decoder nrd_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_byte_i   (cmd_byte_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_byte_o   (rsp_byte_o),
  .mode_strobe_o(mode_strobe_o),
  .addr_q       (addr_q)
);

// File: tb/nib_reg_decoder_tb_top.sv
module nib_reg_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_byte_i = 8'h00;
  logic [23:0] trig_pos_i = 24'h123456;
  logic [23:0] stop_pos_i = 24'hABCDEF;
  logic        rsp_valid_o;
  logic [7:0]  rsp_byte_o;
  logic [7:0]  mode_strobe_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] scratch_model = 8'h00;
  logic [7:0] addr_model = 8'h00;

  always #2ns clk_i = ~clk_i;

  nib_reg_decoder dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [47:0] cat = {stop_pos_i, trig_pos_i};
    if (a == 8'h00) return 8'hA6;
    if (a == 8'h01) return scratch_model;
    if (a >= 8'h10 && a <= 8'h15) return cat[(a - 8'h10)*8 +: 8];
    return 8'h00;
  endfunction

  // drive one command, then one idle cycle; outputs settle before return
  task automatic send(input logic [3:0] op, input logic [3:0] nib);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_byte_i  = {op, nib};
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_byte_i  = 8'h00;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send(4'h0, a[3:0]);
    send(4'h1, a[7:4]);
    addr_model = a;
  endtask

  task automatic wr(input logic [7:0] d);
    send(4'h2, d[3:0]);
    send(4'h3, d[7:4]);
    if (addr_model == 8'h01) scratch_model = d;
  endtask

  task automatic rd_chk(input string req, input logic inc);
    send(4'h4, {3'b000, inc});
    chk({req, " rsp_valid"}, rsp_valid_o, 1);
    chk({req, " rsp_byte"}, rsp_byte_o, exp_rd(addr_model));
    if (inc) addr_model = addr_model + 8'd1;
    @(negedge clk_i);
    chk({req, " single pulse"}, rsp_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R4 reset rsp_valid", rsp_valid_o, 0);
    chk("R9 reset strobe", mode_strobe_o, 0);
    rst_ni = 1'b1;
    // R11-style reset state via ports: address 0 reads ID, scratch reads 0
    rd_chk("R1 reset addr reads id", 1'b0);
    set_addr(8'h01);
    rd_chk("R7 scratch reset", 1'b0);

    // R1 every address through both nibble commands
    for (int a = 0; a < 256; a++) begin
      set_addr(8'(a));
      rd_chk("R1 addr sweep", 1'b0);
    end
    // R1 low nibble only replaces bits 3:0
    set_addr(8'h13);
    send(4'h0, 4'h5);
    addr_model = 8'h15;
    rd_chk("R1 low nibble keeps high", 1'b0);
    send(4'h1, 4'h0);
    addr_model = 8'h05;
    rd_chk("R1 high nibble keeps low", 1'b0);

    // R7 scratch sweep
    for (int d = 0; d < 256; d++) begin
      set_addr(8'h01);
      wr(8'(d));
      rd_chk("R7 scratch sweep", 1'b0);
    end

    // R2 low data alone writes nothing
    set_addr(8'h01);
    wr(8'h3C);
    send(4'h2, 4'h9);
    rd_chk("R2 low nibble no write", 1'b0);
    send(4'h3, 4'h7);
    scratch_model = 8'h79;
    rd_chk("R2 high nibble commits", 1'b0);

    // R3 several pairs to one address, last wins, address unchanged
    set_addr(8'h01);
    wr(8'h55);
    wr(8'hAA);
    wr(8'h5A);
    rd_chk("R3 multi pair last wins", 1'b0);

    // R6 write to id ignored
    set_addr(8'h00);
    wr(8'h00);
    rd_chk("R6 id after write", 1'b0);

    // R8 positions read-only and byte order
    set_addr(8'h10);
    for (int k = 0; k < 6; k++) rd_chk("R8 position byte", 1'b1);
    set_addr(8'h13);
    wr(8'h00);
    rd_chk("R8 write ignored", 1'b0);

    // R9 mode strobes
    for (int d = 1; d < 256; d = d * 3) begin
      set_addr(8'h02);
      send(4'h2, d[3:0]);
      send(4'h3, d[7:4]);
      chk("R9 strobe value", mode_strobe_o, 32'(d[7:0]));
      @(negedge clk_i);
      chk("R9 strobe one cycle", mode_strobe_o, 0);
    end
    rd_chk("R9 mode reads zero", 1'b0);

    // R10 unassigned opcodes ignored
    set_addr(8'h01);
    wr(8'h42);
    for (int op = 5; op < 16; op++) begin
      send(4'(op), 4'hF);
      chk("R10 no response", rsp_valid_o, 0);
      chk("R10 no strobe", mode_strobe_o, 0);
    end
    send(4'h3, 4'h0);
    scratch_model = 8'h02;
    rd_chk("R10 addr and low data unchanged", 1'b0);
    set_addr(8'h77);
    wr(8'hFF);
    rd_chk("R10 unmapped reads zero", 1'b0);

    // R5 incrementing walk over every address with wrap
    set_addr(8'h00);
    for (int a = 0; a < 256; a++) rd_chk("R5 inc walk", 1'b1);
    rd_chk("R5 wrap to 00", 1'b0);
    rd_chk("R5 no inc keeps addr", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule